// File: doc/BRIEF.md
# USB Downstream Attach and Speed Detector

This block watches the single-ended logic levels of the two USB data lines on a downstream port. It decides whether the port is empty, holds a low-speed device, or holds a full-speed device. The class follows from which line the attached device pulls high while idle. A device that can run at high speed first idles like a full-speed device, so it is reported as full speed. Both raw line bits first pass through a two-stage synchronizer. A stability timer then qualifies the synchronized line pair. A state change is taken only after the pair has held one value for a minimum time of 2.5 us, which the block converts to clock cycles from its clock-frequency parameter.

A low-speed or full-speed idle pattern that qualifies while the port is empty declares an attach. The speed code is latched at that moment, and a single-cycle event pulse is raised. A qualified single-ended-zero pattern, with both lines low, declares a detach. Both lines high is invalid and never qualifies. All pins are plain level control and status signals; no data stream passes through the block, so it has no valid/ready handshake.

Top module: `usb_attach_detect`

## Requirements
- R1: While reset is held and in the first cycle after it, `attached`, `is_low_speed` and `attach_event` are all 0.
- R2: On an empty port, the line pair {dp,dm} = 2'b01 (dm high, dp low) held for QUAL_CYCLES consecutive clock samples sets `attached`=1 with `is_low_speed`=1. The outputs change 3 clock edges after the last qualifying sample is taken.
- R3: On an empty port, {dp,dm} = 2'b10 (dp high, dm low) held for QUAL_CYCLES consecutive samples sets `attached`=1 with `is_low_speed`=0, with the same latency as R2.
- R4: Any change of the sampled line pair before QUAL_CYCLES equal samples have been seen restarts the count. QUAL_CYCLES-1 equal samples never change the outputs.
- R5: {dp,dm} = 2'b11 never causes an attach, however long it is held.
- R6: While attached, {dp,dm} = 2'b00 held for QUAL_CYCLES samples clears both `attached` and `is_low_speed`. A shorter single-ended-zero interval has no effect.
- R7: `attach_event` is high for exactly one cycle, in the first cycle in which `attached` reads 1. It is not raised on detach.
- R8: While attached, qualified patterns 2'b01, 2'b10 and 2'b11 leave `attached` and `is_low_speed` unchanged.
- R9: QUAL_CYCLES = ceil(CLK_FREQ_HZ x 2500 ns), which is 30 at 12 MHz and 250 at 100 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_raw | input | 1 | D+ line logic level, asynchronous to clk |
| dm_raw | input | 1 | D- line logic level, asynchronous to clk |
| attached | output | 1 | A device is present |
| is_low_speed | output | 1 | The attached device is low speed (0 when detached or full speed) |
| attach_event | output | 1 | One-cycle pulse when an attach is declared |

## Verification
The lines are driven with clean low-speed and full-speed idle patterns, which tell the two speed codes apart. Runs that stop exactly one sample short of the qualifying length, and single-cycle glitches inside a run, show whether the timer restarts rather than pauses. A long both-high interval and foreign idle patterns while attached show that invalid or unexpected states are ignored. Short and full single-ended-zero intervals separate a line glitch from a true detach.

// File: rtl/usb_attach_pkg.sv
package usb_attach_pkg;

  // Line pair encoded as {dp, dm}
  typedef enum logic [1:0] {
    LN_SE0     = 2'b00,
    LN_LS_IDLE = 2'b01,
    LN_FS_IDLE = 2'b10,
    LN_BAD     = 2'b11
  } line_pair_e;

  // Cycles needed to cover a time window, rounded up
  function automatic int unsigned qual_cycles(input int unsigned clk_hz,
                                              input int unsigned window_ns);
    longint unsigned prod;
    prod = longint'(clk_hz) * longint'(window_ns);
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/attach_sync.sv
module attach_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/attach_stable_timer.sv
module attach_stable_timer
  import usb_attach_pkg::*;
#(
  parameter int QUAL = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_now,
  output line_pair_e cand,
  output logic       stable
);

  localparam int CW = (QUAL > 2) ? $clog2(QUAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= LN_SE0;
      held <= '0;
    end else begin
      cand <= line_pair_e'(line_now);
      if (line_now != cand)  held <= '0;
      else if (held != LAST) held <= held + 1'b1;
    end
  end

  assign stable = (held == LAST);

  // A fresh candidate can never be stable at once
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cand) |-> !stable);

endmodule

// File: rtl/attach_fsm.sv
module attach_fsm
  import usb_attach_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_e cand,
  input  logic       stable,
  output logic       attached,
  output logic       is_low_speed,
  output logic       attach_event
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attached     <= 1'b0;
      is_low_speed <= 1'b0;
      attach_event <= 1'b0;
    end else begin
      attach_event <= 1'b0;
      if (stable) begin
        unique case (cand)
          LN_SE0: if (attached) begin
            attached     <= 1'b0;
            is_low_speed <= 1'b0;
          end
          LN_LS_IDLE: if (!attached) begin
            attached     <= 1'b1;
            is_low_speed <= 1'b1;
            attach_event <= 1'b1;
          end
          LN_FS_IDLE: if (!attached) begin
            attached     <= 1'b1;
            is_low_speed <= 1'b0;
            attach_event <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_event_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    attach_event |-> (attached && !$past(attached)));
  p_event_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    attach_event |=> !attach_event);
  p_speed_needs_attach_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !attached |-> !is_low_speed);
  p_speed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (attached && $past(attached)) |-> $stable(is_low_speed));

endmodule

// File: rtl/usb_attach_detect.sv
module usb_attach_detect
  import usb_attach_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 12_000_000,
  parameter int unsigned QUAL_NS     = 2500,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_raw,
  input  logic dm_raw,
  output logic attached,
  output logic is_low_speed,
  output logic attach_event
);

  localparam int QUAL_RAW    = int'(qual_cycles(CLK_FREQ_HZ, QUAL_NS));
  localparam int QUAL_CYCLES = (QUAL_RAW < 2) ? 2 : QUAL_RAW;

  logic [1:0] line_sync;
  line_pair_e cand;
  logic       stable;

  attach_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({dp_raw, dm_raw}),
    .dout (line_sync)
  );

  attach_stable_timer #(.QUAL(QUAL_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_now(line_sync),
    .cand    (cand),
    .stable  (stable)
  );

  attach_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand        (cand),
    .stable      (stable),
    .attached    (attached),
    .is_low_speed(is_low_speed),
    .attach_event(attach_event)
  );

  // Attach only after a qualified, valid idle pattern
  p_attach_needs_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attached) |-> ($past(stable) && ($past(cand) != LN_BAD)
                         && ($past(cand) != LN_SE0)));
  p_detach_needs_se0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attached) |-> ($past(stable) && ($past(cand) == LN_SE0)));

endmodule

// File: tb/usb_attach_detect_bench.sv
module usb_attach_detect_bench;

  localparam int unsigned CLK_HZ = 100_000_000;
  localparam int QUAL = 250; // R9: ceil(100e6 * 2.5e-6)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b0;
  logic attached, is_low_speed, attach_event;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  usb_attach_detect #(.CLK_FREQ_HZ(CLK_HZ)) u_usb_attach_detect (
    .clk(clk), .rst_n(rst_n), .dp_raw(dp), .dm_raw(dm),
    .attached(attached), .is_low_speed(is_low_speed),
    .attach_event(attach_event)
  );

  // Behavioural reference: sample history with run lengths
  logic [1:0] hv[$];
  int         hr[$];
  bit m_att = 0, m_low = 0, m_evt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv.delete(); hr.delete();
      hv.push_back(2'b00); hr.push_back(1);
      hv.push_back(2'b00); hr.push_back(2);
      hv.push_back(2'b00); hr.push_back(3);
      m_att = 0; m_low = 0; m_evt = 0;
    end else begin
      logic [1:0] v;
      int r;
      v = {dp, dm};
      r = (v == hv[hv.size()-1]) ? hr[hr.size()-1] + 1 : 1;
      hv.push_back(v); hr.push_back(r);
      m_evt = 0;
      if (hr[hr.size()-4] >= QUAL) begin
        case (hv[hv.size()-4])
          2'b00: if (m_att) begin m_att = 0; m_low = 0; end
          2'b01: if (!m_att) begin m_att = 1; m_low = 1; m_evt = 1; end
          2'b10: if (!m_att) begin m_att = 1; m_low = 0; m_evt = 1; end
          default: ;
        endcase
      end
      if (hv.size() > 4) begin void'(hv.pop_front()); void'(hr.pop_front()); end
    end
  end

  task automatic cmp(input string t, input logic got, input bit exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", t, what, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      cmp(tag, attached, m_att, "attached");
      cmp(tag, is_low_speed, m_low, "is_low_speed");
      cmp((tag == "R1") ? "R1" : "R7", attach_event, m_evt, "attach_event");
    end
  end

  task automatic hold(input logic [1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {dp, dm} = v;
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    cmp("R1", attached, 1'b0, "attached in reset");
    cmp("R1", is_low_speed, 1'b0, "is_low_speed in reset");
    cmp("R1", attach_event, 1'b0, "attach_event in reset");
    rst_n = 1'b1;
    hold(2'b00, 20);
    tag = "R4";
    hold(2'b01, QUAL - 1); hold(2'b00, 10);
    hold(2'b01, 100); hold(2'b11, 1); hold(2'b01, QUAL - 1); hold(2'b10, 1);
    hold(2'b01, 40); hold(2'b00, 10);
    tag = "R2";
    hold(2'b01, QUAL + 10);
    cmp("R2", attached, 1'b1, "attached after low-speed idle");
    cmp("R2", is_low_speed, 1'b1, "low-speed code");
    tag = "R8";
    hold(2'b10, QUAL + 20); hold(2'b11, QUAL + 20); hold(2'b01, 30);
    cmp("R8", is_low_speed, 1'b1, "speed kept while attached");
    tag = "R6";
    hold(2'b00, QUAL - 1); hold(2'b01, 20);
    cmp("R6", attached, 1'b1, "short SE0 ignored");
    hold(2'b00, QUAL + 10);
    cmp("R6", attached, 1'b0, "detached after SE0");
    cmp("R6", is_low_speed, 1'b0, "speed cleared on detach");
    tag = "R5";
    hold(2'b11, 3 * QUAL);
    cmp("R5", attached, 1'b0, "both-high never attaches");
    hold(2'b00, 10);
    tag = "R3";
    hold(2'b10, QUAL + 10);
    cmp("R3", attached, 1'b1, "attached after full-speed idle");
    cmp("R3", is_low_speed, 1'b0, "full-speed code");
    tag = "R9";
    hold(2'b00, QUAL + 10);
    hold(2'b10, QUAL);
    hold(2'b00, 1); // exact-length run still qualifies
    hold(2'b00, 5);
    cmp("R9", attached, 1'b1, "exact QUAL samples attach");
    hold(2'b00, QUAL + 10);
    cmp("R9", attached, 1'b0, "final detach");
    finish_run();
  end

endmodule